// File: doc/BRIEF.md
# Acknowledge Frame Transmitter

This block sends back an address over the primary test data line of a scan-port switch. When the connect logic finds that a received select frame carries this port's address, it pulses `start_i`. The transmitter captures the address and sends it as a framed sequence of two-bit line symbols: idle, select, one symbol per address bit, select, idle.

Every output bit changes on the falling edge of the test clock. Bus masters sample on the rising edge, so they see stable data. The output enable is high only while the frame is on the wire. Outside a frame the data line rests high, and the surrounding logic may place it in high impedance or use it for its own purposes. A one-cycle done pulse marks the end of the frame, and the connect controller uses it to close the connection.

All state is clocked on the falling edge of `tck_i`. Reset is synchronous and active high. A synchronous abort input stops a frame part-way through.

Top module: `ackx_tx`

## Requirements
- R1: A frame lasts 2*(ADDR_W+4) clock periods (28 at ADDR_W=10). It is made of symbol pairs in this order: idle, select, ADDR_W data symbols, select, idle.
- R2: Each symbol is two consecutive bit periods. Idle is 1 then 1. Select is 0 then 0. A data one is 0 then 1. A data zero is 1 then 0.
- R3: The first data symbol carries address bit 0, and the rest follow in ascending bit order.
- R4: Outputs change only on the falling edge of `tck_i`. The first bit of the frame is driven at the same falling edge at which `start_i` is sampled high while the block is idle.
- R5: `sdo_oe_o` is high for exactly the frame's bit periods. Whenever it is low, `sdo_o` is 1.
- R6: `done_o` is high for exactly one period, starting at the falling edge after the last idle bit. At that edge `sdo_oe_o` falls.
- R7: When `abort_i` is sampled high, the next falling edge drops `sdo_oe_o`, sets `sdo_o` to 1, and produces no `done_o` for that frame.
- R8: The address is captured at start. Later changes on `addr_i` and `start_i` pulses during a frame have no effect on that frame's bits or its length.
- R9: When `rst_i` is sampled high at a falling edge, `sdo_oe_o`=0, `done_o`=0 and `sdo_o`=1 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock; all state updates on its falling edge |
| rst_i | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Stops the current frame |
| start_i | input | 1 | Begins a frame when the block is idle |
| addr_i | input | ADDR_W | Address to send back |
| sdo_o | output | 1 | Serial acknowledge data |
| sdo_oe_o | output | 1 | High while the frame occupies the line |
| done_o | output | 1 | One-period end-of-frame pulse |

## Verification
A wrong bit counter or a bad captured address shows up on `sdo_o` within one period of the faulty bit. A corrupted start or end decision makes `sdo_oe_o` fall a period early or late, or moves the `done_o` pulse by a period. The bench therefore sweeps every address at the default width and compares all bit periods of each frame against an arithmetic model. On top of that it checks frame length, abort and reset mid-frame, and address changes and repeated start pulses during a frame.

// File: rtl/ackx_pkg.sv
package ackx_pkg;
  typedef enum logic [1:0] {
    SYM_IDLE = 2'd0,
    SYM_SEL  = 2'd1,
    SYM_DATA = 2'd2
  } ackx_sym_e;

  function automatic int frame_bits(input int addr_w);
    return 2 * (addr_w + 4);
  endfunction
endpackage

// File: rtl/ackx_seq.sv
module ackx_seq #(
  parameter int ADDR_W = 10,
  localparam int NBITS = ackx_pkg::frame_bits(ADDR_W),
  localparam int CNT_W = $clog2(NBITS + 1)
) (
  input  logic              tck_i,
  input  logic              rst_i,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              drive_o,
  output logic              fin_o,
  output logic [CNT_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              load;
  logic              adv;

  always_comb begin
    load    = start_i && !busy_q && !abort_i;
    adv     = busy_q && !abort_i && (cnt_q != CNT_W'(NBITS));
    fin_o   = busy_q && !abort_i && (cnt_q == CNT_W'(NBITS));
    drive_o = load || adv;
    idx_o   = load ? '0 : cnt_q;
    addr_o  = load ? addr_i : addr_q;
  end

  always_ff @(negedge tck_i) begin
    if (rst_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
      addr_q <= addr_i;
    end else if (adv) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (fin_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end
  end

  // R1: while busy, the counter never passes the frame length
  p_cnt_bound_r1: assert property (@(negedge tck_i) disable iff (rst_i)
    busy_q |-> (cnt_q <= CNT_W'(NBITS)));
  // R8: a start while busy does not restart the count
  p_no_restart_r8: assert property (@(negedge tck_i) disable iff (rst_i)
    (busy_q && start_i && !abort_i && cnt_q != CNT_W'(NBITS)) |=> (cnt_q != CNT_W'(1)));
endmodule

// File: rtl/ackx_map.sv
module ackx_map #(
  parameter int ADDR_W = 10,
  localparam int NBITS  = ackx_pkg::frame_bits(ADDR_W),
  localparam int NPAIRS = NBITS / 2,
  localparam int CNT_W  = $clog2(NBITS + 1)
) (
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              lvl_o
);
  import ackx_pkg::*;

  logic [CNT_W-1:0] pair;
  logic             phase;
  logic             dbit;
  ackx_sym_e        sym;

  always_comb begin
    pair  = idx_i >> 1;
    phase = idx_i[0];
    dbit  = 1'b0;
    for (int k = 0; k < ADDR_W; k++) begin
      if (pair == CNT_W'(k + 2)) dbit = addr_i[k];
    end
    if (pair == '0 || pair == CNT_W'(NPAIRS - 1))
      sym = SYM_IDLE;
    else if (pair == CNT_W'(1) || pair == CNT_W'(NPAIRS - 2))
      sym = SYM_SEL;
    else
      sym = SYM_DATA;
    unique case (sym)
      SYM_IDLE: lvl_o = 1'b1;
      SYM_SEL:  lvl_o = 1'b0;
      default:  lvl_o = phase ? dbit : !dbit;
    endcase
  end
endmodule

// File: rtl/ackx_tx.sv
module ackx_tx #(
  parameter int ADDR_W = 10
) (
  input  logic              tck_i,
  input  logic              rst_i,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              done_o
);
  localparam int NBITS = ackx_pkg::frame_bits(ADDR_W);
  localparam int CNT_W = $clog2(NBITS + 1);

  logic              drive;
  logic              fin;
  logic [CNT_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_sel;
  logic              lvl;

  ackx_seq #(.ADDR_W(ADDR_W)) seq_i (
    .tck_i(tck_i), .rst_i(rst_i), .abort_i(abort_i), .start_i(start_i),
    .addr_i(addr_i), .drive_o(drive), .fin_o(fin), .idx_o(idx), .addr_o(addr_sel)
  );

  ackx_map #(.ADDR_W(ADDR_W)) map_i (
    .idx_i(idx), .addr_i(addr_sel), .lvl_o(lvl)
  );

  always_ff @(negedge tck_i) begin
    if (rst_i || abort_i) begin
      sdo_oe_o <= 1'b0;
      sdo_o    <= 1'b1;
      done_o   <= 1'b0;
    end else begin
      sdo_oe_o <= drive;
      sdo_o    <= drive ? lvl : 1'b1;
      done_o   <= fin;
    end
  end

  // R1: a frame opens with an idle bit
  p_first_idle_r1: assert property (@(negedge tck_i) disable iff (rst_i)
    $rose(sdo_oe_o) |-> sdo_o);
  // R5: line rests high when not driven
  p_rest_high_r5: assert property (@(negedge tck_i) disable iff (rst_i)
    !sdo_oe_o |-> sdo_o);
  // R6: done follows a driven period and lasts one period
  p_done_after_oe_r6: assert property (@(negedge tck_i) disable iff (rst_i)
    $rose(done_o) |-> $past(sdo_oe_o));
  p_done_single_r6: assert property (@(negedge tck_i) disable iff (rst_i)
    done_o |=> !done_o);
  // R7: abort releases the line at once
  p_abort_release_r7: assert property (@(negedge tck_i) disable iff (rst_i)
    abort_i |=> (!sdo_oe_o && !done_o));
  // R8: a frame is not cut short by further starts
  p_no_early_end_r8: assert property (@(negedge tck_i) disable iff (rst_i)
    (sdo_oe_o && !abort_i) |=> (sdo_oe_o || done_o));
endmodule

// File: tb/ackx_tx_tb_top.sv
module ackx_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int NB = 2 * (AW + 4);

  logic          tck = 1'b1;
  logic          rst = 1'b1;
  logic          abort_s = 1'b0;
  logic          start_s = 1'b0;
  logic [AW-1:0] addr_s = '0;
  logic          sdo, oe, done;
  int            total = 0;
  int            bad = 0;

  always #(CLK_PERIOD / 2) tck = ~tck;

  ackx_tx #(.ADDR_W(AW)) dut_i (
    .tck_i(tck), .rst_i(rst), .abort_i(abort_s), .start_i(start_s),
    .addr_i(addr_s), .sdo_o(sdo), .sdo_oe_o(oe), .done_o(done)
  );

  function automatic logic exp_bit(input int j, input logic [AW-1:0] a);
    int p = j / 2;
    int ph = j % 2;
    if (p == 0 || p == AW + 3) return 1'b1;
    if (p == 1 || p == AW + 2) return 1'b0;
    return (ph == 1) ? a[p-2] : !a[p-2];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t act=%b exp=%b", req, $time, act, exp);
    end
  endtask

  // wait until the middle of the high phase (away from the falling edge)
  task automatic mid;
    @(posedge tck); #1;
  endtask

  // send one frame; optionally disturb addr and start during it
  task automatic frame(input logic [AW-1:0] a, input bit disturb);
    mid(); start_s = 1'b1; addr_s = a;
    @(negedge tck); #1; start_s = 1'b0;
    for (int j = 0; j < NB; j++) begin
      mid();
      if (disturb && j == 6) begin addr_s = ~a; start_s = 1'b1; end
      if (disturb && j == 9) start_s = 1'b0;
      chk("R5 oe in frame", oe, 1'b1);
      chk("R1 R2 R3 R8 bit", sdo, exp_bit(j, a));
      chk("R6 no early done", done, 1'b0);
    end
    start_s = 1'b0;
    mid();
    chk("R6 done pulse", done, 1'b1);
    chk("R6 oe falls", oe, 1'b0);
    chk("R5 rest high", sdo, 1'b1);
    mid();
    chk("R6 done single", done, 1'b0);
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mid(); mid();
    rst = 1'b0;
    mid();
    chk("R9 reset oe", oe, 1'b0);
    chk("R9 reset done", done, 1'b0);
    chk("R9 reset sdo", sdo, 1'b1);
    // R4: first bit appears half a period after start is driven
    mid(); start_s = 1'b1; addr_s = 10'h2A5;
    #2; chk("R4 no change before falling edge", oe, 1'b0);
    @(negedge tck); #1; start_s = 1'b0;
    chk("R4 first bit at falling edge", oe, 1'b1);
    chk("R4 first bit idle", sdo, 1'b1);
    repeat (NB + 2) mid();
    // R1 R2 R3: every address
    for (int a = 0; a < (1 << AW); a++) frame(AW'(a), 1'b0);
    // R8: disturb address and start inside frames
    frame(10'h001, 1'b1);
    frame(10'h3FE, 1'b1);
    // R7: abort mid-frame
    mid(); start_s = 1'b1; addr_s = 10'h155;
    @(negedge tck); #1; start_s = 1'b0;
    repeat (7) mid();
    abort_s = 1'b1;
    mid(); abort_s = 1'b0;
    chk("R7 abort oe", oe, 1'b0);
    chk("R7 abort sdo", sdo, 1'b1);
    for (int k = 0; k < NB + 2; k++) begin
      mid();
      chk("R7 no done after abort", done, 1'b0);
      chk("R7 stays off", oe, 1'b0);
    end
    frame(10'h0F0, 1'b0);
    // R9: reset mid-frame
    mid(); start_s = 1'b1; addr_s = 10'h333;
    @(negedge tck); #1; start_s = 1'b0;
    repeat (12) mid();
    rst = 1'b1;
    mid(); rst = 1'b0;
    chk("R9 reset mid oe", oe, 1'b0);
    chk("R9 reset mid sdo", sdo, 1'b1);
    for (int k = 0; k < NB + 2; k++) begin
      mid();
      chk("R9 no done after reset", done, 1'b0);
    end
    frame(10'h3FF, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule